// File: doc/BRIEF.md
# Level-Shifted Multicarrier Modulator for a Five-Level Clamped Leg

This block drives the eight gate signals of one phase leg in a five-level diode-clamped inverter. A signed digital reference sample is compared against a stack of triangular carriers. All carriers run at the same frequency and with the same peak-to-peak swing. Each carrier is shifted into its own band, and together the bands cover the full signed range of the reference without gaps or overlap. The number of carriers that the reference lies above gives an output level from 0 (bottom) to 4 (top). A registered decoder turns that level into a fixed switch pattern: an upper group of four switches and a lower group of four, paired position by position as complementary devices.

All carriers are derived from one shared up/down ramp counter. A prescaler sets how many clocks each ramp step lasts, and so sets the carrier period. The reference is latched once per carrier period, at the instant the ramp reaches its top. The comparison then runs every clock against that held value, which gives regularly sampled PWM. Reset is asserted asynchronously and released through a two-stage synchronizer. While the block is in reset, every gate is off.

The level count and band size come from parameters. The band width is 2^REF_W / (NUM_LEVELS-1), which must be a power of two.

Top module: `mlpwm_modulator`

## Requirements
- R1: While rst_n is low, and until the first clock edge after the internal reset has released (the third rising edge that sees rst_n high), all eight gate outputs are 0.
- R2: For every position i, gate_hi[i] and gate_lo[i] are never both 1, at any time.
- R3: Once the first decoded level has been loaded after reset, exactly four of the eight gate outputs are 1 in every cycle.
- R4: Bit i of gate_hi (i = 0 is the switch nearest the positive rail) is 1 exactly when the level L satisfies L >= 4 - i. gate_lo is the bitwise complement of gate_hi. So level 4 drives gate_hi = 4'b1111, and each step down clears the lowest set bit of gate_hi and sets the same bit of gate_lo. All five levels occur during normal operation.
- R5: The level is the number of carriers k (k = 0..3) for which u > k*BAND + ramp. Here u is the held reference plus 2^(REF_W-1), taken as unsigned, and ramp is the current ramp value. The gate outputs show the decoded level one clock after the ramp and the held reference take the values that produce it.
- R6: After reset the ramp starts at 0 counting up. It moves one step every per_div+1 clocks, turns from BAND-1 back down, and turns at 0 back up. Its value changes by at most 1 per clock.
- R7: The held reference loads ref_in only on the clock where a ramp step happens while the ramp is at BAND-1 and rising. Changes on ref_in at any other time have no effect on the gate outputs.
- R8: A reference at the most negative code holds the leg at level 0 (gate_lo all ones) at every ramp position. A reference at the most positive code never goes below level 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_div | input | DIV_W | Clocks per ramp step, minus one |
| ref_in | input | REF_W | Signed reference sample, two's complement |
| gate_hi | output | NUM_LEVELS-1 | Upper switch gates, bit 0 nearest the positive rail |
| gate_lo | output | NUM_LEVELS-1 | Lower switch gates, bit i complementary to gate_hi[i] |

## Verification
The bench builds the modulator with an 8-bit reference, five levels and an 8-bit divider, so each band is 64 codes wide and a full carrier period at per_div = 0 lasts only 126 clocks. This short period puts many reference captures, every level transition and all ramp turnarounds within a few thousand cycles. Divider values of 0, 1 and 3 show that the step rate scales the period without changing the band geometry. A reference that changes every clock shows that only values present at the ramp peak reach the outputs.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } ramp_dir_e;

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier
  import mlpwm_pkg::*;
#(
  parameter int REF_W      = 12,
  parameter int NUM_LEVELS = 5,
  parameter int DIV_W      = 16,
  localparam int NC        = NUM_LEVELS - 1,
  localparam int BAND      = (1 << REF_W) / NC,
  localparam int RAMP_W    = $clog2(BAND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  per_div,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              peak_o
);

  localparam logic [RAMP_W-1:0] RAMP_TOP = RAMP_W'(BAND - 1);

  logic [DIV_W-1:0]  pre_q, pre_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  ramp_dir_e         dir_q, dir_d;
  logic              tick;

  always_comb begin
    tick   = (pre_q >= per_div);
    pre_d  = tick ? '0 : pre_q + 1'b1;
    ramp_d = ramp_q;
    dir_d  = dir_q;
    if (dir_q == DIR_UP) begin
      if (ramp_q == RAMP_TOP) begin
        dir_d  = DIR_DN;
        ramp_d = ramp_q - 1'b1;
      end else begin
        ramp_d = ramp_q + 1'b1;
      end
    end else begin
      if (ramp_q == '0) begin
        dir_d  = DIR_UP;
        ramp_d = ramp_q + 1'b1;
      end else begin
        ramp_d = ramp_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      dir_q  <= DIR_UP;
    end else if (tick) begin
      ramp_q <= ramp_d;
      dir_q  <= dir_d;
    end
  end

  assign ramp_o = ramp_q;
  assign peak_o = tick && (dir_q == DIR_UP) && (ramp_q == RAMP_TOP);

endmodule

// File: rtl/mlpwm_compare.sv
module mlpwm_compare #(
  parameter int REF_W      = 12,
  parameter int NUM_LEVELS = 5,
  localparam int NC        = NUM_LEVELS - 1,
  localparam int BAND      = (1 << REF_W) / NC,
  localparam int RAMP_W    = $clog2(BAND),
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic signed [REF_W-1:0] ref_hold,
  input  logic [RAMP_W-1:0]       ramp,
  output logic [LVL_W-1:0]        level
);

  logic [REF_W-1:0] ref_u;
  logic [NC-1:0]    above;

  assign ref_u = {~ref_hold[REF_W-1], ref_hold[REF_W-2:0]};

  for (genvar k = 0; k < NC; k++) begin : g_band
    logic [REF_W-1:0] carrier;
    assign carrier  = REF_W'(k * BAND) + {{(REF_W-RAMP_W){1'b0}}, ramp};
    assign above[k] = (ref_u > carrier);
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < NC; k++) begin
      level = level + LVL_W'(above[k]);
    end
  end

endmodule

// File: rtl/mlpwm_gate_decode.sv
module mlpwm_gate_decode #(
  parameter int NUM_LEVELS = 5,
  localparam int NC        = NUM_LEVELS - 1,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [LVL_W-1:0] level,
  output logic [NC-1:0]    gate_hi,
  output logic [NC-1:0]    gate_lo
);

  logic [NC-1:0] hi_d, lo_d;
  logic [NC-1:0] hi_q, lo_q;

  for (genvar i = 0; i < NC; i++) begin : g_pair
    assign hi_d[i] = (int'(level) >= (NC - i));
    assign lo_d[i] = ~hi_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign gate_hi = hi_q;
  assign gate_lo = lo_q;

endmodule

// File: rtl/mlpwm_modulator.sv
module mlpwm_modulator #(
  parameter int REF_W      = 12,
  parameter int NUM_LEVELS = 5,
  parameter int DIV_W      = 16,
  localparam int NC        = NUM_LEVELS - 1,
  localparam int BAND      = (1 << REF_W) / NC,
  localparam int RAMP_W    = $clog2(BAND),
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        per_div,
  input  logic signed [REF_W-1:0] ref_in,
  output logic [NC-1:0]           gate_hi,
  output logic [NC-1:0]           gate_lo
);

  logic [1:0]              rst_sync_q;
  logic                    rst_core_n;
  logic [RAMP_W-1:0]       ramp_w;
  logic                    peak_w;
  logic signed [REF_W-1:0] ref_hold_q;
  logic [LVL_W-1:0]        level_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  mlpwm_carrier #(
    .REF_W      (REF_W),
    .NUM_LEVELS (NUM_LEVELS),
    .DIV_W      (DIV_W)
  ) u_carrier (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .per_div (per_div),
    .ramp_o  (ramp_w),
    .peak_o  (peak_w)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ref_hold_q <= '0;
    end else if (peak_w) begin
      ref_hold_q <= ref_in;
    end
  end

  mlpwm_compare #(
    .REF_W      (REF_W),
    .NUM_LEVELS (NUM_LEVELS)
  ) u_compare (
    .ref_hold (ref_hold_q),
    .ramp     (ramp_w),
    .level    (level_w)
  );

  mlpwm_gate_decode #(
    .NUM_LEVELS (NUM_LEVELS)
  ) u_decode (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_en (1'b1),
    .level   (level_w),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
  );

endmodule

// File: rtl/mlpwm_mod_chk.sv
module mlpwm_mod_chk #(
  parameter int REF_W      = 12,
  parameter int NUM_LEVELS = 5,
  localparam int NC        = NUM_LEVELS - 1,
  localparam int BAND      = (1 << REF_W) / NC,
  localparam int RAMP_W    = $clog2(BAND)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_core_n,
  input logic [NC-1:0]           gate_hi,
  input logic [NC-1:0]           gate_lo,
  input logic [RAMP_W-1:0]       ramp,
  input logic                    peak,
  input logic signed [REF_W-1:0] ref_in,
  input logic signed [REF_W-1:0] ref_hold
);

  // R1: gates stay off while the external reset is low
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_gates_off_in_reset_R1 : assert (gate_hi == '0 && gate_lo == '0);
    end
  end

  assert_no_shoot_through_R2 : assert property (@(posedge clk) disable iff (!rst_core_n)
    (gate_hi & gate_lo) == '0);

  assert_four_on_R3 : assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(rst_core_n) |-> ($countones({gate_hi, gate_lo}) == NC));

  assert_upper_thermometer_R4 : assert property (@(posedge clk) disable iff (!rst_core_n)
    (gate_hi & ~{1'b1, gate_hi[NC-1:1]}) == '0);

  assert_ramp_single_step_R6 : assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> (ramp == $past(ramp)) || (ramp == $past(ramp) + 1'b1) || (ramp == $past(ramp) - 1'b1));

  assert_hold_only_at_peak_R7 : assert property (@(posedge clk) disable iff (!rst_core_n)
    !peak |=> $stable(ref_hold));

  assert_hold_loads_ref_R7 : assert property (@(posedge clk) disable iff (!rst_core_n)
    peak |=> (ref_hold == $past(ref_in)));

endmodule

bind mlpwm_modulator mlpwm_mod_chk #(
  .REF_W      (REF_W),
  .NUM_LEVELS (NUM_LEVELS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo),
  .ramp       (ramp_w),
  .peak       (peak_w),
  .ref_in     (ref_in),
  .ref_hold   (ref_hold_q)
);

// File: tb/mlpwm_modulator_tb.sv
module mlpwm_modulator_tb;

  localparam int REF_W      = 8;
  localparam int NUM_LEVELS = 5;
  localparam int DIV_W      = 8;
  localparam int NC         = NUM_LEVELS - 1;
  localparam int BAND       = (1 << REF_W) / NC;

  logic                    clk;
  logic                    rst_n;
  logic [DIV_W-1:0]        per_div;
  logic signed [REF_W-1:0] ref_in;
  logic [NC-1:0]           gate_hi;
  logic [NC-1:0]           gate_lo;

  int n_checks = 0;
  int n_errors = 0;

  mlpwm_modulator #(
    .REF_W      (REF_W),
    .NUM_LEVELS (NUM_LEVELS),
    .DIV_W      (DIV_W)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .per_div (per_div),
    .ref_in  (ref_in),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model, advanced on each rising edge
  bit            m_s1, m_s2, m_loaded, m_up;
  int            m_pre, m_ramp, m_hold;
  logic [NC-1:0] m_hi, m_lo;
  int            seen_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_loaded = 0;
      m_pre = 0; m_ramp = 0; m_up = 1; m_hold = 0;
      m_hi = '0; m_lo = '0;
    end else begin
      if (m_s2) begin
        int lvl;
        int u;
        lvl = 0;
        u = m_hold + (1 << (REF_W - 1));
        for (int k = 0; k < NC; k++) if (u > k * BAND + m_ramp) lvl++;
        for (int i = 0; i < NC; i++) begin
          m_hi[i] = (lvl >= NC - i);
          m_lo[i] = !(lvl >= NC - i);
        end
        seen_mask |= (1 << lvl);
        m_loaded = 1;
        if (m_pre >= int'(per_div)) begin
          if (m_up && m_ramp == BAND - 1) m_hold = int'(ref_in);
          m_pre = 0;
          if (m_up) begin
            if (m_ramp == BAND - 1) begin m_up = 0; m_ramp--; end
            else m_ramp++;
          end else begin
            if (m_ramp == 0) begin m_up = 1; m_ramp++; end
            else m_ramp--;
          end
        end else begin
          m_pre++;
        end
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  // Per-cycle comparison, made before inputs move
  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp) begin
      n_checks++;
      if (gate_hi !== m_hi || gate_lo !== m_lo) begin
        n_errors++;
        $display("FAIL R5/R6/R7 t=%0t gates hi=%b lo=%b expected hi=%b lo=%b",
                 $time, gate_hi, gate_lo, m_hi, m_lo);
      end
      n_checks++;
      if ((gate_hi & gate_lo) !== '0) begin
        n_errors++;
        $display("FAIL R2 t=%0t overlap hi=%b lo=%b expected no common bit", $time, gate_hi, gate_lo);
      end
      if (m_loaded) begin
        n_checks++;
        if ($countones({gate_hi, gate_lo}) != NC) begin
          n_errors++;
          $display("FAIL R3 t=%0t on-count %0d expected %0d", $time,
                   $countones({gate_hi, gate_lo}), NC);
        end
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check_gates(input string tag, input logic [NC-1:0] exp_hi,
                             input logic [NC-1:0] exp_lo);
    n_checks++;
    if (gate_hi !== exp_hi || gate_lo !== exp_lo) begin
      n_errors++;
      $display("FAIL %s hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, exp_hi, exp_lo);
    end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    per_div = '0;
    ref_in = '0;
    seen_mask = 0;
    step(3);
    check_gates("R1 in reset", '0, '0);
    rst_n = 1'b1;
    run_cmp = 1;
    step(1);
    check_gates("R1 after release, sync pending", '0, '0);

    // Constant references across the range
    ref_in = -8'sd128; step(260);
    // R8: bottom code at every ramp position gives level 0
    for (int i = 0; i < 130; i++) begin
      step(1);
      check_gates("R8 bottom code", '0, '1);
    end
    ref_in = -8'sd50;  step(260);
    ref_in = 8'sd0;    step(260);
    ref_in = 8'sd40;   step(260);
    ref_in = 8'sd127;  step(260);
    // R8: top code never below level 3 (gate_hi[1] on)
    for (int i = 0; i < 130; i++) begin
      step(1);
      n_checks++;
      if (gate_hi[1] !== 1'b1) begin
        n_errors++;
        $display("FAIL R8 top code hi=%b expected hi[1]=1", gate_hi);
      end
    end

    // R7: reference moving every clock, only peak samples count
    for (int i = 0; i < 768; i++) begin
      ref_in = REF_W'((i * 37) % 256 - 128);
      step(1);
    end

    // R6: slower ramp steps
    per_div = 8'd3;
    for (int i = 0; i < 1500; i++) begin
      ref_in = REF_W'(((i / 7) * 11) % 256 - 128);
      step(1);
    end
    per_div = 8'd1;
    ref_in = 8'sd90; step(600);

    // R1: mid-run reset
    rst_n = 1'b0;
    step(1);
    check_gates("R1 mid-run reset", '0, '0);
    step(2);
    check_gates("R1 reset held", '0, '0);
    rst_n = 1'b1;
    per_div = '0;
    ref_in = -8'sd100;
    step(400);

    // R4: every level seen during the run
    n_checks++;
    if (seen_mask != ((1 << NUM_LEVELS) - 1)) begin
      n_errors++;
      $display("FAIL R4 levels seen mask=%b expected %b", seen_mask[NUM_LEVELS-1:0],
               NUM_LEVELS'((1 << NUM_LEVELS) - 1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule